// File: doc/BRIEF.md
# Parity-Protected Instruction Cache

A small direct-mapped instruction cache placed between a fetch port and a slower backing memory. Every tag entry and every data word is stored together with an even-parity bit, and both are checked on every lookup. A clean hit answers in the cycle after the request. A miss fetches the whole line from backing memory and answers once the line is complete.

Soft errors never reach the requester as data. A faulty tag entry is treated as a miss and the line is fetched again. A faulty data word clears the line's valid bit and returns an abort flag with no data. All of this happens in hardware on the lookup path, with no interrupt. Test-only inputs flip a stored parity bit so that faults can be injected.

Top module: `icache_par`

## Requirements
- R1: After reset every line is invalid, `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_valid_o` are 0. The first access to any address misses.
- R2: A miss raises `mem_req_valid_o`. The line-aligned word address (the low 3 offset bits cleared) is held stable until the cycle in which `mem_req_ready_i` is 1.
- R3: A refill takes exactly eight beats on `mem_rsp_valid_i`, stored as words 0 to 7 in order. Idle cycles between beats are allowed. In the cycle after the eighth beat, `rsp_valid_o` is 1, `rsp_abort_o` is 0 and `rsp_data_o` holds the requested word.
- R4: A request to a present, error-free line produces `rsp_valid_o` with the stored word in the next cycle and issues no backing-memory request. The word address splits into offset [2:0], set index [5:3] and tag [11:6].
- R5: A tag entry whose stored parity does not match its valid and tag bits is treated as a miss, and the line is refilled.
- R6: A data word with bad parity on a tag hit gives `rsp_valid_o`=1, `rsp_abort_o`=1 and `rsp_data_o`=0 in the next cycle. It also invalidates the line, so the next access to that line misses and refills.
- R7: A data parity fault affects only the faulty word. Other words of the same line still hit normally until the faulty word is read.
- R8: While a refill is in progress, `req_ready_o` is 0 and requests are ignored. No response appears other than the one for the missed address.
- R9: `inj_tag_i` inverts the stored tag parity bit of set `inj_idx_i`. `inj_data_i` inverts the stored parity bit of word `inj_word_i` in that set. Each flip takes effect at the clock edge, and two flips restore the original parity.
- R10: A refill replaces the line in its set. An address with the previous tag in that set then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Fetch request |
| req_addr_i | input | 12 | Fetch word address |
| req_ready_o | output | 1 | Cache accepts a request |
| rsp_valid_o | output | 1 | Response valid |
| rsp_data_o | output | 32 | Instruction word, 0 on abort |
| rsp_abort_o | output | 1 | Fetch abort due to data parity fault |
| mem_req_valid_o | output | 1 | Line fetch request to backing memory |
| mem_req_addr_o | output | 12 | Line-aligned word address |
| mem_req_ready_i | input | 1 | Backing memory accepts line request |
| mem_rsp_valid_i | input | 1 | Refill beat valid |
| mem_rsp_data_i | input | 32 | Refill beat data |
| inj_tag_i | input | 1 | Test: flip tag parity bit |
| inj_data_i | input | 1 | Test: flip data parity bit |
| inj_idx_i | input | 3 | Test: set index for injection |
| inj_word_i | input | 3 | Test: word offset for data injection |

## Verification
The assertions check on every cycle the following cause-and-effect rules:
- a tag fault always leads to a backing-memory request;
- a data fault on a hit always yields an aborted, zeroed response;
- a hit never issues a memory request;
- the line request is held until accepted;
- the eighth beat always completes with a clean response.

Only the bench scenarios can show the data values themselves, by sweeping every word of every set against a computed memory image. The same applies to the fact that invalidation makes the following access miss, to the isolation of a fault to one word, and to conflict replacement.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MREQ,
    ST_FILL
  } fill_state_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
  parameter int SETS  = 8,
  parameter int TAG_W = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [$clog2(SETS)-1:0] rd_idx_i,
  output logic                    rd_valid_o,
  output logic [TAG_W-1:0]        rd_tag_o,
  output logic                    rd_perr_o,
  input  logic                    wr_en_i,
  input  logic [$clog2(SETS)-1:0] wr_idx_i,
  input  logic                    wr_valid_i,
  input  logic [TAG_W-1:0]        wr_tag_i,
  input  logic                    inj_en_i,
  input  logic [$clog2(SETS)-1:0] inj_idx_i
);
  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  par_q;
  logic [TAG_W-1:0] tag_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      par_q   <= '0;
      for (int i = 0; i < SETS; i++) tag_q[i] <= '0;
    end else begin
      if (wr_en_i) begin
        valid_q[wr_idx_i] <= wr_valid_i;
        tag_q[wr_idx_i]   <= wr_tag_i;
        par_q[wr_idx_i]   <= ^{wr_valid_i, wr_tag_i};
      end
      // test hook: inverts the stored bit, wins over a same-cycle write
      if (inj_en_i) par_q[inj_idx_i] <= ~par_q[inj_idx_i];
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_perr_o  = ^{par_q[rd_idx_i], valid_q[rd_idx_i], tag_q[rd_idx_i]};
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
  parameter int SETS       = 8,
  parameter int LINE_WORDS = 8,
  parameter int DATA_W     = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [$clog2(SETS)-1:0]       rd_idx_i,
  input  logic [$clog2(LINE_WORDS)-1:0] rd_off_i,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic                          rd_perr_o,
  input  logic                          wr_en_i,
  input  logic [$clog2(SETS)-1:0]       wr_idx_i,
  input  logic [$clog2(LINE_WORDS)-1:0] wr_off_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic                          inj_en_i,
  input  logic [$clog2(SETS)-1:0]       inj_idx_i,
  input  logic [$clog2(LINE_WORDS)-1:0] inj_off_i
);
  localparam int IDX_W = $clog2(SETS);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int DEPTH = SETS * LINE_WORDS;
  localparam int A_W   = IDX_W + OFF_W;

  logic [DATA_W-1:0] word_q [DEPTH];
  logic [DEPTH-1:0]  par_q;

  logic [A_W-1:0] rd_a, wr_a, inj_a;
  assign rd_a  = {rd_idx_i, rd_off_i};
  assign wr_a  = {wr_idx_i, wr_off_i};
  assign inj_a = {inj_idx_i, inj_off_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q <= '0;
      for (int i = 0; i < DEPTH; i++) word_q[i] <= '0;
    end else begin
      if (wr_en_i) begin
        word_q[wr_a] <= wr_data_i;
        par_q[wr_a]  <= ^wr_data_i;
      end
      if (inj_en_i) par_q[inj_a] <= ~par_q[inj_a];
    end
  end

  assign rd_data_o = word_q[rd_a];
  assign rd_perr_o = par_q[rd_a] ^ (^word_q[rd_a]);
endmodule

// File: rtl/icache_par.sv
module icache_par
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int SETS       = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  input  logic [ADDR_W-1:0]             req_addr_i,
  output logic                          req_ready_o,
  output logic                          rsp_valid_o,
  output logic [DATA_W-1:0]             rsp_data_o,
  output logic                          rsp_abort_o,
  output logic                          mem_req_valid_o,
  output logic [ADDR_W-1:0]             mem_req_addr_o,
  input  logic                          mem_req_ready_i,
  input  logic                          mem_rsp_valid_i,
  input  logic [DATA_W-1:0]             mem_rsp_data_i,
  input  logic                          inj_tag_i,
  input  logic                          inj_data_i,
  input  logic [$clog2(SETS)-1:0]       inj_idx_i,
  input  logic [$clog2(LINE_WORDS)-1:0] inj_word_i
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_WORDS - 1);

  fill_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OFF_W-1:0]  cnt_q;
  logic [DATA_W-1:0] pick_q;
  logic              rsp_valid_q, rsp_abort_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic [OFF_W-1:0] req_off;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  assign req_off = req_addr_i[OFF_W-1:0];
  assign req_idx = req_addr_i[OFF_W +: IDX_W];
  assign req_tag = req_addr_i[ADDR_W-1 -: TAG_W];

  logic             t_valid, t_perr;
  logic [TAG_W-1:0] t_tag;
  logic [DATA_W-1:0] d_data;
  logic             d_perr;

  logic req_fire, tag_hit, beat, last_beat, inval;
  assign req_fire  = req_valid_i && (state_q == ST_IDLE);
  assign tag_hit   = t_valid && !t_perr && (t_tag == req_tag);
  assign beat      = (state_q == ST_FILL) && mem_rsp_valid_i;
  assign last_beat = beat && (cnt_q == LAST_OFF);
  assign inval     = req_fire && tag_hit && d_perr;

  logic             tw_en, tw_valid;
  logic [IDX_W-1:0] tw_idx;
  logic [TAG_W-1:0] tw_tag;
  always_comb begin
    tw_en    = inval || last_beat;
    tw_valid = last_beat;
    tw_idx   = last_beat ? addr_q[OFF_W +: IDX_W] : req_idx;
    tw_tag   = last_beat ? addr_q[ADDR_W-1 -: TAG_W] : req_tag;
  end

  icache_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_idx_i(req_idx), .rd_valid_o(t_valid), .rd_tag_o(t_tag), .rd_perr_o(t_perr),
    .wr_en_i(tw_en), .wr_idx_i(tw_idx), .wr_valid_i(tw_valid), .wr_tag_i(tw_tag),
    .inj_en_i(inj_tag_i), .inj_idx_i(inj_idx_i)
  );

  icache_data_store #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_idx_i(req_idx), .rd_off_i(req_off), .rd_data_o(d_data), .rd_perr_o(d_perr),
    .wr_en_i(beat), .wr_idx_i(addr_q[OFF_W +: IDX_W]), .wr_off_i(cnt_q),
    .wr_data_i(mem_rsp_data_i),
    .inj_en_i(inj_data_i), .inj_idx_i(inj_idx_i), .inj_off_i(inj_word_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      cnt_q       <= '0;
      pick_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_abort_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      rsp_abort_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_fire) begin
          if (tag_hit) begin
            rsp_valid_q <= 1'b1;
            rsp_abort_q <= d_perr;
            rsp_data_q  <= d_perr ? '0 : d_data;  // bad word never leaves
          end else begin
            addr_q  <= req_addr_i;
            state_q <= ST_MREQ;
          end
        end
        ST_MREQ: if (mem_req_ready_i) begin
          cnt_q   <= '0;
          state_q <= ST_FILL;
        end
        ST_FILL: if (beat) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == addr_q[OFF_W-1:0]) pick_q <= mem_rsp_data_i;
          if (last_beat) begin
            state_q     <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= (cnt_q == addr_q[OFF_W-1:0]) ? mem_rsp_data_i : pick_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_MREQ);
  assign mem_req_addr_o  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign rsp_valid_o     = rsp_valid_q;
  assign rsp_abort_o     = rsp_abort_q;
  assign rsp_data_o      = rsp_data_q;

  // R5: corrupt tag entry must go to backing memory
  a_r5_tag_err_misses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_fire && t_perr |=> mem_req_valid_o && !rsp_valid_o);
  // R6: data fault on a hit aborts with zero data
  a_r6_data_err_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_fire && tag_hit && d_perr |=> rsp_valid_o && rsp_abort_o && (rsp_data_o == '0));
  // R4: hit does not touch backing memory
  a_r4_hit_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_fire && tag_hit |=> !mem_req_valid_o && rsp_valid_o);
  // R2: line request held until accepted
  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));
  // R3: eighth beat completes the refill with a clean response
  a_r3_fill_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_beat |=> rsp_valid_o && !rsp_abort_o && req_ready_o);
  // R8: no response while busy
  a_r8_busy_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> !rsp_valid_o);
endmodule

// File: tb/icache_par_tb.sv
`timescale 1ns/1ps
module icache_par_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [11:0] req_addr_i = '0;
  logic        req_ready_o, rsp_valid_o, rsp_abort_o;
  logic [31:0] rsp_data_o;
  logic        mem_req_valid_o;
  logic [11:0] mem_req_addr_o;
  logic        mem_req_ready_i = 1'b0;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        inj_tag_i = 1'b0, inj_data_i = 1'b0;
  logic [2:0]  inj_idx_i = '0, inj_word_i = '0;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk_i = ~clk_i;

  icache_par dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .req_ready_o(req_ready_o),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o), .rsp_abort_o(rsp_abort_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_ready_i(mem_req_ready_i), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i),
    .inj_tag_i(inj_tag_i), .inj_data_i(inj_data_i),
    .inj_idx_i(inj_idx_i), .inj_word_i(inj_word_i)
  );

  function automatic logic [31:0] mem_word(input int a);
    return (32'(a) * 32'h0101_0407) ^ 32'hC3A5_0000;
  endfunction

  function automatic int mk(input int tag, input int idx, input int off);
    return (tag << 6) | (idx << 3) | off;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic inject(input bit tag, input int idx, input int word);
    @(negedge clk_i);
    inj_tag_i = tag; inj_data_i = !tag;
    inj_idx_i = 3'(idx); inj_word_i = 3'(word);
    @(negedge clk_i);
    inj_tag_i = 1'b0; inj_data_i = 1'b0;
  endtask

  task automatic fetch(input int a, input bit exp_miss, input bit exp_abort, input string rq);
    int base;
    base = a & ~7;
    @(negedge clk_i);
    chk(rq, req_ready_o, 1);
    req_valid_i = 1'b1; req_addr_i = 12'(a);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (!exp_miss) begin
      chk(rq, mem_req_valid_o, 0);
      chk(rq, rsp_valid_o, 1);
      chk(rq, rsp_abort_o, exp_abort);
      chk(rq, rsp_data_o, exp_abort ? 32'h0 : mem_word(a));
    end else begin
      chk(rq, rsp_valid_o, 0);
      chk(rq, mem_req_valid_o, 1);
      chk("R2", mem_req_addr_o, 32'(base));
      req_valid_i = 1'b1; req_addr_i = 12'(a ^ 12'h040);  // stray request while busy
      @(negedge clk_i);
      chk("R2", mem_req_valid_o, 1);
      chk("R8", req_ready_o, 0);
      req_valid_i = 1'b0; mem_req_ready_i = 1'b1;
      @(negedge clk_i);
      mem_req_ready_i = 1'b0;
      chk("R2", mem_req_valid_o, 0);
      for (int w = 0; w < 8; w++) begin
        if (w == 4) @(negedge clk_i);
        mem_rsp_valid_i = 1'b1; mem_rsp_data_i = mem_word(base + w);
        @(negedge clk_i);
        mem_rsp_valid_i = 1'b0;
        if (w < 7) chk("R3", rsp_valid_o, 0);
      end
      chk("R3", rsp_valid_o, 1);
      chk("R3", rsp_abort_o, 0);
      chk("R3", rsp_data_o, mem_word(a));
      @(negedge clk_i);
      chk("R8", rsp_valid_o, 0);
      chk("R8", mem_req_valid_o, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", req_ready_o, 1);
    chk("R1", rsp_valid_o, 0);
    chk("R1", mem_req_valid_o, 0);

    // R1/R3/R4 sweep: first touch of each set misses, then every word hits
    for (int s = 0; s < 8; s++) begin
      fetch(mk(0, s, s), 1, 0, "R1");
      for (int o = 0; o < 8; o++) fetch(mk(0, s, o), 0, 0, "R4");
    end

    // R10 conflict replacement
    fetch(mk(5, 2, 1), 1, 0, "R10");
    fetch(mk(5, 2, 7), 0, 0, "R10");
    fetch(mk(0, 2, 1), 1, 0, "R10");
    fetch(mk(0, 3, 0), 0, 0, "R10");

    // R5 tag parity fault -> miss and refill
    inject(1, 4, 0);
    fetch(mk(0, 4, 3), 1, 0, "R5");
    fetch(mk(0, 4, 3), 0, 0, "R5");

    // R9 double flip restores parity
    inject(1, 7, 0);
    inject(1, 7, 0);
    fetch(mk(0, 7, 0), 0, 0, "R9");
    inject(0, 5, 4);
    inject(0, 5, 4);
    fetch(mk(0, 5, 4), 0, 0, "R9");

    // R6 data parity fault -> abort, then invalidated line refills
    inject(0, 1, 6);
    fetch(mk(0, 1, 6), 0, 1, "R6");
    fetch(mk(0, 1, 6), 1, 0, "R6");
    fetch(mk(0, 1, 2), 0, 0, "R6");

    // R7 fault isolated to one word
    inject(0, 6, 2);
    fetch(mk(0, 6, 5), 0, 0, "R7");
    fetch(mk(0, 6, 2), 0, 1, "R7");
    fetch(mk(0, 6, 5), 1, 0, "R6");

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule